// File: doc/BRIEF.md
# Interrupt Recognition and Stack Frame Sequencer

This block sits beside the control unit of a small 8-bit accumulator CPU and owns the moment at which a hardware interrupt is taken. An instruction is never broken off. Requests are judged only when the core signals that the current instruction has finished. The block combines a vector of pending requests with a vector of per-source enables and the interrupt mask bit that it holds. It then either lets the core fetch the next instruction or starts interrupt entry for the most urgent source.

On entry the block writes a five-byte frame to a byte-wide stack port, one byte per cycle. The frame holds the return address, the index-low register, the accumulator and the condition code byte. The block then sets the mask bit and presents the index of the winning source. The index-high register is never part of the frame, so a service routine that uses it saves it on its own.

For the return, the block reads the frame back in reverse order and presents the restored values, including the restored mask bit. If an enabled request is still waiting at that point and the restored mask allows it, the block goes straight into a new entry. It flags the opcode that the return already fetched so that the core drops it.

Top module: `irq_stack_seq`

## Requirements
- R1: When `insn_done` is seen in the idle state and no enabled request can be taken, `fetch_next` pulses high for exactly one cycle on the cycle after the strobe, and no stack write occurs.
- R2: A request is taken only when `mask_out` is 0 and both the pending bit and the enable bit of that source are 1. A masked or disabled request leads to `fetch_next`, not to a stack write.
- R3: When several enabled requests are pending, the lowest source index wins. `vec_idx` carries that index as a binary number.
- R4: Entry writes one byte per cycle, starting on the cycle after the decision. The five writes go to addresses SP, SP-1, SP-2, SP-3 and SP-4. The bytes are, in that order, return address bits 7:0, return address bits 15:8, index-low register, accumulator, and the CCR byte with bit 3 replaced by the mask bit in force at entry.
- R5: Entry makes exactly five writes, so the index-high register is never stacked. `sp_out` ends 5 lower, and `vec_valid` pulses on the cycle after the last write.
- R6: While `vec_valid` is high, `mask_out` reads 1, which blocks nested entry.
- R7: `rti_go` starts five reads, one per cycle, from SP+1 upward. The bytes read are CCR, accumulator, index-low, return address high and return address low. One cycle after the last read, `rest_valid` is high with the restored values, `mask_out` equals bit 3 of the restored CCR, and `sp_out` is 5 higher.
- R8: In the cycle after `rest_valid`, if an enabled request is pending and the restored mask is 0, a new entry starts at once. `prefetch_drop` and the first stack write are high together, and the frame holds the restored values. Otherwise `fetch_next` pulses in that cycle.
- R9: Synchronous active-high `rst` sets `mask_out` to 1 and `sp_out` to `SP_TOP`, and leaves no strobe or stack access active.
- R10: `insn_done` pulses that arrive while a frame is being written are ignored. They cause no `fetch_next`, no extra write and no second entry.
- R11: `mask_wr` in the idle state loads `mask_wdata` into the mask bit, which shows on `mask_out` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pend | input | N_SRC | Pending request per source |
| req_en | input | N_SRC | Enable per source |
| insn_done | input | 1 | Current instruction has completed |
| rti_go | input | 1 | Start of the return-from-interrupt sequence |
| ret_pc | input | 16 | Return address to stack on entry |
| acc_in | input | 8 | Accumulator value to stack |
| idx_lo_in | input | 8 | Index-low register value to stack |
| ccr_in | input | 8 | Condition code byte from the core |
| mask_wr | input | 1 | Write strobe for the mask bit |
| mask_wdata | input | 1 | New mask value |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | SP_W | Stack byte address |
| stk_wdata | output | 8 | Byte to write |
| stk_rdata | input | 8 | Byte read, valid in the same cycle as `stk_re` |
| mask_out | output | 1 | Current interrupt mask bit |
| fetch_next | output | 1 | Core may fetch the next instruction |
| vec_valid | output | 1 | Entry finished, `vec_idx` valid |
| vec_idx | output | IDX_W | Index of the source being serviced |
| prefetch_drop | output | 1 | Opcode fetched by the return must be dropped |
| rest_valid | output | 1 | Restored values valid |
| rest_pc | output | 16 | Restored return address |
| rest_acc | output | 8 | Restored accumulator |
| rest_idx_lo | output | 8 | Restored index-low register |
| rest_ccr | output | 8 | Restored condition code byte |
| sp_out | output | SP_W | Current stack pointer |

## Verification
The completion of a return and the recognition of a new request fall in the same cycle. The restored mask from the pulled CCR decides, in that cycle, whether a request held pending during the return is taken. The bench keeps one enabled source pending across a return whose frame carries a clear mask bit. It then checks that the drop flag and the first write of the new frame appear together, that the new frame carries the restored values, and that no fetch permit is given. The same pending source is then held across a return whose stored CCR has the mask bit set, and only the fetch permit may appear.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_PUSH,
      SQ_PULL,
      SQ_RTIEND
   } sq_state_e;

   localparam int FRAME_LEN = 5;
   localparam int CNT_W     = 3;

   typedef logic [7:0] byte_t;
endpackage

// File: rtl/irqs_prio_pick.sv
module irqs_prio_pick #(
   parameter int N_SRC = 8,
   parameter int IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] pend,
   input  logic [N_SRC-1:0] en,
   output logic             hit_any,
   output logic [IDX_W-1:0] hit_idx
);
   logic [N_SRC-1:0] hit;

   generate
      if (N_SRC < 2) begin : g_bad_n
         $error("irqs_prio_pick: N_SRC must be at least 2");
      end
      for (genvar g = 0; g < N_SRC; g++) begin : g_hit
         assign hit[g] = pend[g] & en[g];
      end
   endgenerate

   always_comb begin
      hit_any = |hit;
      hit_idx = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (hit[i]) hit_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irqs_sp_unit.sv
module irqs_sp_unit #(
   parameter int             SP_W   = 8,
   parameter logic [SP_W-1:0] SP_TOP = '1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            dec,
   input  logic            inc,
   output logic [SP_W-1:0] sp
);
   always_ff @(posedge clk) begin
      if (rst)      sp <= SP_TOP;
      else if (dec) sp <= sp - SP_W'(1);
      else if (inc) sp <= sp + SP_W'(1);
   end

   a_r4_sp_steps_down: assert property (@(posedge clk) disable iff (rst)
      dec |=> sp == $past(sp) - SP_W'(1));
   a_r7_sp_steps_up: assert property (@(posedge clk) disable iff (rst)
      inc |=> sp == $past(sp) + SP_W'(1));
   a_r10_one_direction: assert property (@(posedge clk) disable iff (rst)
      !(dec && inc));
endmodule

// File: rtl/irqs_frame_reg.sv
module irqs_frame_reg
   import irqs_pkg::*;
#(
   parameter int LEN = FRAME_LEN
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load,
   input  logic [LEN-1:0][7:0]  din,
   input  logic [CNT_W-1:0]     sel,
   output byte_t                dout
);
   logic [LEN-1:0][7:0] slot;

   generate
      for (genvar g = 0; g < LEN; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (rst)       slot[g] <= '0;
            else if (load) slot[g] <= din[g];
         end
      end
   endgenerate

   always_comb begin
      dout = '0;
      for (int i = 0; i < LEN; i++) begin
         if (sel == CNT_W'(i)) dout = slot[i];
      end
   end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
   import irqs_pkg::*;
#(
   parameter int              N_SRC    = 8,
   parameter int              SP_W     = 8,
   parameter logic [SP_W-1:0] SP_TOP   = '1,
   parameter int              MASK_BIT = 3,
   parameter int              IDX_W    = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_SRC-1:0] req_pend,
   input  logic [N_SRC-1:0] req_en,
   input  logic             insn_done,
   input  logic             rti_go,
   input  logic [15:0]      ret_pc,
   input  logic [7:0]       acc_in,
   input  logic [7:0]       idx_lo_in,
   input  logic [7:0]       ccr_in,
   input  logic             mask_wr,
   input  logic             mask_wdata,
   output logic             stk_we,
   output logic             stk_re,
   output logic [SP_W-1:0]  stk_addr,
   output logic [7:0]       stk_wdata,
   input  logic [7:0]       stk_rdata,
   output logic             mask_out,
   output logic             fetch_next,
   output logic             vec_valid,
   output logic [IDX_W-1:0] vec_idx,
   output logic             prefetch_drop,
   output logic             rest_valid,
   output logic [15:0]      rest_pc,
   output logic [7:0]       rest_acc,
   output logic [7:0]       rest_idx_lo,
   output logic [7:0]       rest_ccr,
   output logic [SP_W-1:0]  sp_out
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

   generate
      if (MASK_BIT < 0 || MASK_BIT > 7) begin : g_bad_mask
         $error("irq_stack_seq: MASK_BIT must address a bit of the CCR byte");
      end
      if (SP_W < 4) begin : g_bad_sp
         $error("irq_stack_seq: SP_W too small to hold one frame");
      end
      if (N_SRC < 2 || N_SRC > 64) begin : g_bad_n
         $error("irq_stack_seq: N_SRC out of range");
      end
   endgenerate

   sq_state_e              state;
   logic [CNT_W-1:0]       cnt;
   logic                   mask_q;
   logic [IDX_W-1:0]       vec_q;
   logic                   fetch_q, vecv_q, drop_q, restv_q;
   byte_t                  rest_q [FRAME_LEN];
   logic                   hit_any;
   logic [IDX_W-1:0]       hit_idx;
   logic                   take;
   logic                   last;
   logic                   load_frame;
   logic [FRAME_LEN-1:0][7:0] frame_din;
   byte_t                  frame_byte;
   byte_t                  ccr_mod;
   logic [SP_W-1:0]        sp;

   irqs_prio_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
      .pend    (req_pend),
      .en      (req_en),
      .hit_any (hit_any),
      .hit_idx (hit_idx)
   );

   irqs_sp_unit #(.SP_W(SP_W), .SP_TOP(SP_TOP)) u_sp (
      .clk (clk),
      .rst (rst),
      .dec (stk_we),
      .inc (stk_re),
      .sp  (sp)
   );

   irqs_frame_reg #(.LEN(FRAME_LEN)) u_frame (
      .clk  (clk),
      .rst  (rst),
      .load (load_frame),
      .din  (frame_din),
      .sel  (cnt),
      .dout (frame_byte)
   );

   assign take = hit_any && !mask_q;
   assign last = (cnt == LAST);

   always_comb begin
      ccr_mod           = ccr_in;
      ccr_mod[MASK_BIT] = mask_q;
   end

   always_comb begin
      load_frame = take && (((state == SQ_IDLE) && insn_done && !rti_go) ||
                            (state == SQ_RTIEND));
      if (state == SQ_RTIEND) begin
         for (int i = 0; i < FRAME_LEN; i++) frame_din[i] = rest_q[FRAME_LEN - 1 - i];
      end else begin
         frame_din[0] = ret_pc[7:0];
         frame_din[1] = ret_pc[15:8];
         frame_din[2] = idx_lo_in;
         frame_din[3] = acc_in;
         frame_din[4] = ccr_mod;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= SQ_IDLE;
         cnt     <= '0;
         mask_q  <= 1'b1;
         vec_q   <= '0;
         fetch_q <= 1'b0;
         vecv_q  <= 1'b0;
         drop_q  <= 1'b0;
         restv_q <= 1'b0;
         for (int i = 0; i < FRAME_LEN; i++) rest_q[i] <= '0;
      end else begin
         fetch_q <= 1'b0;
         vecv_q  <= 1'b0;
         drop_q  <= 1'b0;
         restv_q <= 1'b0;
         unique case (state)
            SQ_IDLE: begin
               if (mask_wr) mask_q <= mask_wdata;
               if (rti_go) begin
                  state <= SQ_PULL;
                  cnt   <= '0;
               end else if (insn_done) begin
                  if (take) begin
                     state <= SQ_PUSH;
                     cnt   <= '0;
                     vec_q <= hit_idx;
                  end else begin
                     fetch_q <= 1'b1;
                  end
               end
            end
            SQ_PUSH: begin
               if (last) begin
                  state  <= SQ_IDLE;
                  cnt    <= '0;
                  mask_q <= 1'b1;
                  vecv_q <= 1'b1;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            SQ_PULL: begin
               for (int i = 0; i < FRAME_LEN; i++) begin
                  if (cnt == CNT_W'(i)) rest_q[i] <= stk_rdata;
               end
               if (last) begin
                  state   <= SQ_RTIEND;
                  cnt     <= '0;
                  mask_q  <= rest_q[0][MASK_BIT];
                  restv_q <= 1'b1;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            SQ_RTIEND: begin
               cnt <= '0;
               if (take) begin
                  state  <= SQ_PUSH;
                  vec_q  <= hit_idx;
                  drop_q <= 1'b1;
               end else begin
                  state   <= SQ_IDLE;
                  fetch_q <= 1'b1;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign stk_we        = (state == SQ_PUSH);
   assign stk_re        = (state == SQ_PULL);
   assign stk_addr      = stk_we ? sp : sp + SP_W'(1);
   assign stk_wdata     = frame_byte;
   assign mask_out      = mask_q;
   assign fetch_next    = fetch_q;
   assign vec_valid     = vecv_q;
   assign vec_idx       = vec_q;
   assign prefetch_drop = drop_q;
   assign rest_valid    = restv_q;
   assign rest_ccr      = rest_q[0];
   assign rest_acc      = rest_q[1];
   assign rest_idx_lo   = rest_q[2];
   assign rest_pc       = {rest_q[3], rest_q[4]};
   assign sp_out        = sp;

   // run length of consecutive stack writes, for the frame-size check
   logic [3:0] wr_run;
   always_ff @(posedge clk) begin
      if (rst)         wr_run <= '0;
      else if (stk_we) wr_run <= wr_run + 4'd1;
      else             wr_run <= '0;
   end

   a_r5_five_byte_frame: assert property (@(posedge clk) disable iff (rst)
      $fell(stk_we) |-> (wr_run == 4'd5) && vec_valid);
   a_r6_mask_on_vector: assert property (@(posedge clk) disable iff (rst)
      vec_valid |-> mask_out);
   a_r2_masked_no_write: assert property (@(posedge clk) disable iff (rst)
      (!stk_we && !stk_re && !rest_valid && insn_done && !rti_go && mask_out) |=> !stk_we);
   a_r8_drop_with_push: assert property (@(posedge clk) disable iff (rst)
      prefetch_drop |-> stk_we && !fetch_next);
   a_r1_single_outcome: assert property (@(posedge clk) disable iff (rst)
      $onehot0({fetch_next, vec_valid, prefetch_drop}));
   a_r10_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
      !(stk_we && stk_re));
   a_r7_mask_from_pulled_ccr: assert property (@(posedge clk) disable iff (rst)
      rest_valid |-> mask_out == rest_ccr[MASK_BIT]);
endmodule

// File: tb/irq_stack_seq_tb_top.sv
module irq_stack_seq_tb_top;
   localparam int N   = 8;
   localparam int SPW = 8;
   localparam int IW  = 3;

   logic            clk = 1'b0;
   logic            rst;
   logic [N-1:0]    req_pend, req_en;
   logic            insn_done, rti_go;
   logic [15:0]     ret_pc;
   logic [7:0]      acc_in, idx_lo_in, ccr_in;
   logic            mask_wr, mask_wdata;
   logic            stk_we, stk_re;
   logic [SPW-1:0]  stk_addr;
   logic [7:0]      stk_wdata, stk_rdata;
   logic            mask_out, fetch_next, vec_valid, prefetch_drop, rest_valid;
   logic [IW-1:0]   vec_idx;
   logic [15:0]     rest_pc;
   logic [7:0]      rest_acc, rest_idx_lo, rest_ccr;
   logic [SPW-1:0]  sp_out;

   logic [7:0]      mem [256];
   logic            tb_we;
   logic [7:0]      tb_addr, tb_data;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   irq_stack_seq #(.N_SRC(N), .SP_W(SPW), .SP_TOP(8'hFF), .MASK_BIT(3)) dut_i (
      .clk(clk), .rst(rst), .req_pend(req_pend), .req_en(req_en),
      .insn_done(insn_done), .rti_go(rti_go), .ret_pc(ret_pc), .acc_in(acc_in),
      .idx_lo_in(idx_lo_in), .ccr_in(ccr_in), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
      .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
      .stk_rdata(stk_rdata), .mask_out(mask_out), .fetch_next(fetch_next),
      .vec_valid(vec_valid), .vec_idx(vec_idx), .prefetch_drop(prefetch_drop),
      .rest_valid(rest_valid), .rest_pc(rest_pc), .rest_acc(rest_acc),
      .rest_idx_lo(rest_idx_lo), .rest_ccr(rest_ccr), .sp_out(sp_out)
   );

   always @(posedge clk) begin
      if (stk_we)     mem[stk_addr] <= stk_wdata;
      else if (tb_we) mem[tb_addr]  <= tb_data;
   end
   assign stk_rdata = mem[stk_addr];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // five writes starting at the current cycle, then the vector strobe
   task automatic expect_push(input logic [7:0] sp0, input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] b4,
                              input logic [IW-1:0] idx, input bit busy_pulse);
      logic [7:0] exp_b [5];
      exp_b[0] = b0; exp_b[1] = b1; exp_b[2] = b2; exp_b[3] = b3; exp_b[4] = b4;
      for (int k = 0; k < 5; k++) begin
         chk("R4 write strobe", 32'(stk_we), 32'd1);
         chk("R4 write address", 32'(stk_addr), 32'(sp0 - 8'(k)));
         chk("R4 write byte", 32'(stk_wdata), 32'(exp_b[k]));
         chk("R10 no fetch during push", 32'(fetch_next), 32'd0);
         insn_done = busy_pulse && (k == 1);
         step();
      end
      insn_done = 1'b0;
      chk("R5 vector strobe after five writes", 32'(vec_valid), 32'd1);
      chk("R5 no sixth write", 32'(stk_we), 32'd0);
      chk("R3 vector index", 32'(vec_idx), 32'(idx));
      chk("R6 mask set on entry", 32'(mask_out), 32'd1);
      chk("R5 sp lowered by five", 32'(sp_out), 32'(sp0 - 8'd5));
      step();
      chk("R10 no late fetch", 32'(fetch_next), 32'd0);
      chk("R10 no second entry", 32'(stk_we), 32'd0);
   endtask

   task automatic run_entry(input logic [15:0] pc, input logic [7:0] a, input logic [7:0] x,
                            input logic [7:0] ccr, input logic [7:0] exp_ccr,
                            input logic [IW-1:0] idx, input bit busy_pulse);
      logic [7:0] sp0;
      sp0 = sp_out;
      ret_pc = pc; acc_in = a; idx_lo_in = x; ccr_in = ccr;
      insn_done = 1'b1;
      step();
      insn_done = 1'b0;
      expect_push(sp0, pc[7:0], pc[15:8], x, a, exp_ccr, idx, busy_pulse);
   endtask

   task automatic expect_no_take(input string tag);
      insn_done = 1'b1;
      step();
      insn_done = 1'b0;
      chk({tag, " fetch permit"}, 32'(fetch_next), 32'd1);
      chk({tag, " no stack write"}, 32'(stk_we), 32'd0);
      step();
      chk({tag, " fetch is one cycle"}, 32'(fetch_next), 32'd0);
   endtask

   task automatic run_return(input logic [15:0] pc, input logic [7:0] a, input logic [7:0] x,
                             input logic [7:0] ccr, input bit reentry);
      logic [7:0] sp0;
      sp0 = sp_out;
      rti_go = 1'b1;
      step();
      rti_go = 1'b0;
      for (int k = 0; k < 5; k++) begin
         chk("R7 read strobe", 32'(stk_re), 32'd1);
         chk("R7 read address", 32'(stk_addr), 32'(sp0 + 8'(k + 1)));
         step();
      end
      chk("R7 restore valid", 32'(rest_valid), 32'd1);
      chk("R7 restored pc", 32'(rest_pc), 32'(pc));
      chk("R7 restored acc", 32'(rest_acc), 32'(a));
      chk("R7 restored index-low", 32'(rest_idx_lo), 32'(x));
      chk("R7 restored ccr", 32'(rest_ccr), 32'(ccr));
      chk("R7 mask from ccr bit 3", 32'(mask_out), 32'(ccr[3]));
      chk("R7 sp raised by five", 32'(sp_out), 32'(sp0 + 8'd5));
      step();
      if (reentry) begin
         chk("R8 prefetch drop", 32'(prefetch_drop), 32'd1);
         chk("R8 no fetch permit", 32'(fetch_next), 32'd0);
      end else begin
         chk("R8 fetch permit after return", 32'(fetch_next), 32'd1);
         chk("R8 no drop", 32'(prefetch_drop), 32'd0);
         chk("R8 no entry", 32'(stk_we), 32'd0);
      end
   endtask

   task automatic preload(input logic [7:0] addr, input logic [7:0] data);
      tb_we = 1'b1; tb_addr = addr; tb_data = data;
      step();
      tb_we = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) step();
      rst = 1'b0;
      step();
      chk("R9 mask after reset", 32'(mask_out), 32'd1);
      chk("R9 sp after reset", 32'(sp_out), 32'hFF);
      chk("R9 no write", 32'(stk_we), 32'd0);
      chk("R9 no read", 32'(stk_re), 32'd0);
      chk("R9 no strobes", 32'({fetch_next, vec_valid, prefetch_drop, rest_valid}), 32'd0);
   endtask

   task automatic t_masked();
      req_pend = 8'h20; req_en = 8'h20;
      expect_no_take("R2 masked request");
   endtask

   task automatic t_mask_write_and_disabled();
      mask_wr = 1'b1; mask_wdata = 1'b0;
      step();
      mask_wr = 1'b0;
      chk("R11 mask cleared", 32'(mask_out), 32'd0);
      req_pend = 8'h20; req_en = 8'h00;
      expect_no_take("R2 disabled request");
      req_pend = 8'h00; req_en = 8'hFF;
      expect_no_take("R1 nothing pending");
   endtask

   task automatic t_priority_entry();
      req_pend = 8'h64; req_en = 8'h60;
      run_entry(16'h1234, 8'h56, 8'h78, 8'hAC, 8'hA4, 3'd5, 1'b0);
   endtask

   task automatic t_plain_return();
      req_pend = 8'h00;
      run_return(16'h1234, 8'h56, 8'h78, 8'hA4, 1'b0);
      chk("R8 sp back at top", 32'(sp_out), 32'hFF);
   endtask

   task automatic t_busy_ignore();
      req_pend = 8'h80; req_en = 8'h80;
      run_entry(16'hBEEF, 8'h11, 8'h22, 8'h00, 8'h00, 3'd7, 1'b1);
   endtask

   task automatic t_return_into_entry();
      req_pend = 8'h02; req_en = 8'h02;
      run_return(16'hBEEF, 8'h11, 8'h22, 8'h00, 1'b1);
      expect_push(8'hFF, 8'hEF, 8'hBE, 8'h22, 8'h11, 8'h00, 3'd1, 1'b0);
   endtask

   task automatic t_return_masked();
      preload(8'hFB, 8'h08);
      preload(8'hFC, 8'h9A);
      preload(8'hFD, 8'hBC);
      preload(8'hFE, 8'hCD);
      preload(8'hFF, 8'hEF);
      req_pend = 8'h02; req_en = 8'h02;
      run_return(16'hCDEF, 8'h9A, 8'hBC, 8'h08, 1'b0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      rst = 1'b1; req_pend = '0; req_en = '0; insn_done = 1'b0; rti_go = 1'b0;
      ret_pc = '0; acc_in = '0; idx_lo_in = '0; ccr_in = '0;
      mask_wr = 1'b0; mask_wdata = 1'b0; tb_we = 1'b0; tb_addr = '0; tb_data = '0;
      t_reset();
      t_masked();
      t_mask_write_and_disabled();
      t_priority_entry();
      t_plain_return();
      t_busy_ignore();
      t_return_into_entry();
      t_return_masked();
      repeat (2) step();
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule